// File: doc/BRIEF.md
# Shadowed Nonvolatile Configuration Bank

This block holds a small bank of configuration words. Each word has two copies: a volatile shadow that every read returns, and a nonvolatile copy that survives a power cycle. The nonvolatile array is modelled inside the block as a register array that keeps its contents through reset and starts from a factory fill value. A programming timer in the block sets how long each nonvolatile write takes.

A single volatile control register at address 0 holds a mode bit. When the mode bit is clear, each write to a word also programs that word's nonvolatile copy. The bank is then busy for a set number of cycles and accepts no access until the programming ends. When the mode bit is set, writes change only the shadow and finish at once. Those writes are lost at the next reset, so this mode can take any number of writes without wearing the array. On every reset the bank copies the nonvolatile words into the shadows, one word per cycle, before it accepts any access.

Top module: `nvsb_bank`

## Requirements
- R1: After reset is released, `ready_o` stays low for exactly NUM_REGS sampled cycles while the shadows reload, then rises. `busy_o` is low throughout this time.
- R2: After reload, a read of address k (1..NUM_REGS) returns the nonvolatile content of word k-1. Before any write has committed, that content is NV_INIT.
- R3: When the mode bit is 0, an accepted write to a word address updates the shadow and drives `busy_o` high for exactly PROG_CYCLES cycles, starting the cycle after acceptance. `ready_o` is low for that whole time.
- R4: A request made while `ready_o` is low, during reload or during programming, is not accepted. A stalled write leaves the shadow unchanged, and a stalled read leaves `rdata_o` unchanged.
- R5: When the mode bit is 1, an accepted write to a word address updates only the shadow. `busy_o` stays low and `ready_o` stays high.
- R6: After a reset, each shadow holds the last value written to it while the mode bit was 0. Writes made while the mode bit was 1 are gone.
- R7: The mode bit is volatile. After any reset it reads 0, whatever was written before.
- R8: A reset during programming aborts it. `busy_o` drops at once, and the word keeps its earlier nonvolatile value.
- R9: Address 0 is the control register. Bit 7 is the mode bit and holds the written value. All other bits read 0.
- R10: An accepted read loads `rdata_o` at the next clock edge. In every cycle without an accepted read, `rdata_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; acts as a power cycle |
| req_i | input | 1 | Access request, accepted in a cycle where `ready_o` is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (3) | 0 = control register, 1..NUM_REGS = shadowed words |
| wdata_i | input | DATA_W (8) | Write data |
| ready_o | output | 1 | High when the bank can accept an access |
| busy_o | output | 1 | High while a nonvolatile word is being programmed |
| rdata_o | output | DATA_W (8) | Registered read data |

## Verification
The hardest state to reach is a reset that lands in the middle of programming. The bench must then show that the word falls back to its older nonvolatile value and does not take the value its shadow was showing. The bench starts a write-through, waits two busy cycles, pulls reset and reloads, then reads that word back together with its neighbours. A write and a read are also held on the bus while the bank is busy and during reload. The read-back after these stalled requests shows that neither one got in.

// File: rtl/nvsb_pkg.sv
`timescale 1ns/1ps
package nvsb_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_WORD = 2'd2
  } acc_sel_e;
endpackage

// File: rtl/nvsb_nv_array.sv
`timescale 1ns/1ps
module nvsb_nv_array #(
  parameter int unsigned          NUM_WORDS   = 7,
  parameter int unsigned          DATA_W      = 8,
  parameter int unsigned          PROG_CYCLES = 20000,
  parameter logic [DATA_W-1:0]    NV_INIT     = '0,
  localparam int unsigned         IDX_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned         CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic [IDX_W-1:0]  prog_idx_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);
  // nonvolatile storage: never cleared by reset, factory-filled
  logic [DATA_W-1:0] mem_q [NUM_WORDS] = '{default: NV_INIT};

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              commit;

  assign commit = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      pend_idx_q  <= '0;
      pend_data_q <= '0;
    end else if (prog_start_i && !busy_q) begin
      busy_q      <= 1'b1;
      cnt_q       <= CNT_W'(PROG_CYCLES - 1);
      pend_idx_q  <= prog_idx_i;
      pend_data_q <= prog_data_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // cell update only at the end of the programming window
  always_ff @(posedge clk_i) begin
    if (commit) mem_q[pend_idx_q] <= pend_data_q;
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign busy_o    = busy_q;
endmodule

// File: rtl/nvsb_boot_seq.sv
`timescale 1ns/1ps
module nvsb_boot_seq #(
  parameter int unsigned NUM_WORDS = 7,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             load_en_o,
  output logic [IDX_W-1:0] load_idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (idx_q == LAST) done_q <= 1'b1;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  assign load_en_o  = !done_q;
  assign load_idx_o = idx_q;
  assign done_o     = done_q;
endmodule

// File: rtl/nvsb_shadow_file.sv
`timescale 1ns/1ps
module nvsb_shadow_file
  import nvsb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 7,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned MODE_BIT  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_mode_i,
  input  logic              rd_en_i,
  input  acc_sel_e          rd_sel_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              mode_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [NUM_WORDS];
  logic              mode_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] ctrl_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) word_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (load_en_i && load_idx_i == IDX_W'(i))    word_q[i] <= load_data_i;
        else if (wr_en_i && wr_idx_i == IDX_W'(i))   word_q[i] <= wr_data_i;
      end
    end
  end

  // mode is volatile: always returns to write-through
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= 1'b0;
    else if (ctrl_we_i) mode_q <= ctrl_mode_i;
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[MODE_BIT] = mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) begin
      case (rd_sel_i)
        SEL_CTRL: rdata_q <= ctrl_word;
        SEL_WORD: rdata_q <= word_q[rd_idx_i];
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/nvsb_bank.sv
`timescale 1ns/1ps
module nvsb_bank
  import nvsb_pkg::*;
#(
  parameter int unsigned       NUM_REGS    = 7,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       PROG_CYCLES = 20000,
  parameter int unsigned       MODE_BIT    = 7,
  parameter logic [DATA_W-1:0] NV_INIT     = '0,
  localparam int unsigned      ADDR_W      = $clog2(NUM_REGS + 1),
  localparam int unsigned      IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              boot_done;
  logic              load_en;
  logic [IDX_W-1:0]  load_idx;
  logic [DATA_W-1:0] nv_rd_data;
  logic              nv_busy;
  logic              mode_q;
  logic              acc;
  acc_sel_e          sel;
  logic [IDX_W-1:0]  word_idx;
  logic              shadow_we;
  logic              prog_start;
  logic              ctrl_we;
  logic              rd_en;

  assign ready_o = boot_done && !nv_busy;
  assign busy_o  = nv_busy;
  assign acc     = req_i && ready_o;

  always_comb begin
    if (addr_i == '0)                   sel = SEL_CTRL;
    else if (int'(addr_i) <= NUM_REGS)  sel = SEL_WORD;
    else                                sel = SEL_NONE;
  end

  assign word_idx   = IDX_W'(addr_i - ADDR_W'(1));
  assign shadow_we  = acc && we_i && (sel == SEL_WORD);
  assign prog_start = shadow_we && !mode_q;
  assign ctrl_we    = acc && we_i && (sel == SEL_CTRL);
  assign rd_en      = acc && !we_i;

  nvsb_boot_seq #(
    .NUM_WORDS (NUM_REGS),
    .IDX_W     (IDX_W)
  ) boot_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_en_o  (load_en),
    .load_idx_o (load_idx),
    .done_o     (boot_done)
  );

  nvsb_nv_array #(
    .NUM_WORDS   (NUM_REGS),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES),
    .NV_INIT     (NV_INIT)
  ) nv_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_start_i (prog_start),
    .prog_idx_i   (word_idx),
    .prog_data_i  (wdata_i),
    .rd_idx_i     (load_idx),
    .rd_data_o    (nv_rd_data),
    .busy_o       (nv_busy)
  );

  nvsb_shadow_file #(
    .NUM_WORDS (NUM_REGS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .MODE_BIT  (MODE_BIT)
  ) shadow_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en),
    .load_idx_i  (load_idx),
    .load_data_i (nv_rd_data),
    .wr_en_i     (shadow_we),
    .wr_idx_i    (word_idx),
    .wr_data_i   (wdata_i),
    .ctrl_we_i   (ctrl_we),
    .ctrl_mode_i (wdata_i[MODE_BIT]),
    .rd_en_i     (rd_en),
    .rd_sel_i    (sel),
    .rd_idx_i    (word_idx),
    .mode_o      (mode_q),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/nvsb_bank_chk.sv
`timescale 1ns/1ps
module nvsb_bank_chk #(
  parameter int unsigned NUM_REGS    = 7,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROG_CYCLES = 20000,
  parameter int unsigned ADDR_W      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              boot_done_i,
  input logic              mode_i
);
  logic        word_wr;
  int unsigned busy_cnt;

  assign word_wr = req_i && ready_o && we_i && (addr_i != '0) && (int'(addr_i) <= NUM_REGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  p_boot_blocks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_done_i |-> !ready_o);

  p_busy_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);

  p_prog_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_wr && !mode_i) |=> busy_o);

  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == PROG_CYCLES));

  p_shadow_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_wr && mode_i) |=> (!busy_o && ready_o));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && ready_o && !we_i) |=> $stable(rdata_o));
endmodule

bind nvsb_bank nvsb_bank_chk #(
  .NUM_REGS    (NUM_REGS),
  .DATA_W      (DATA_W),
  .PROG_CYCLES (PROG_CYCLES),
  .ADDR_W      (ADDR_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .ready_o     (ready_o),
  .busy_o      (busy_o),
  .rdata_o     (rdata_o),
  .boot_done_i (boot_done),
  .mode_i      (mode_q)
);

// File: tb/nvsb_bank_tb_top.sv
`timescale 1ns/1ps
module nvsb_bank_tb_top;
  localparam int N    = 7;
  localparam int DW   = 8;
  localparam int PC   = 6;
  localparam int AW   = 3;
  localparam logic [7:0] INIT = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, busy;
  logic [DW-1:0] rdata;

  int vec = 0;
  int err = 0;
  logic [7:0] exp_nv [1:N];
  logic [7:0] exp_sh [1:N];

  always #2.5 clk = ~clk;

  nvsb_bank #(
    .NUM_REGS(N), .DATA_W(DW), .PROG_CYCLES(PC), .MODE_BIT(7), .NV_INIT(INIT)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .busy_o(busy), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  endtask

  task automatic wait_ready;
    while (!ready) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wait_ready();
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    wait_ready();
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  // release reset at a negedge; returns number of not-ready samples
  task automatic power_cycle(output int n);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!ready) begin
      n++;
      @(negedge clk);
    end
  endtask

  // write-through with stalled write and read during busy; returns busy length
  task automatic wr_nv(input logic [AW-1:0] a, input logic [7:0] d, output int n);
    logic [7:0] held;
    held = rdata;
    wr(a, d);
    chk("R3 busy after accept", busy, 1);
    n = 0;
    while (busy) begin
      if (n < 2) begin req = 1'b1; we = 1'b1; addr = a; wdata = ~d; end
      else if (n == 2) begin req = 1'b1; we = 1'b0; addr = a; end
      else req = 1'b0;
      if (ready) chk("R3 ready low while busy", ready, 0);
      n++;
      @(negedge clk);
    end
    req = 1'b0; we = 1'b0;
    chk("R4 stalled read left rdata", rdata, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    err++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    int n;
    logic [7:0] v;
    for (int k = 1; k <= N; k++) begin exp_nv[k] = INIT; exp_sh[k] = INIT; end

    // R1: reload window and reset state
    power_cycle(n);
    chk("R1 reload cycles", n, N);
    chk("R1 busy low", busy, 0);
    chk("R10 rdata reset", rdata, 0);
    rd(0, v); chk("R7 mode low after reset", v, 8'h00);

    // R2: shadows reloaded from factory fill
    for (int k = 1; k <= N; k++) begin
      rd(AW'(k), v); chk($sformatf("R2 word %0d", k), v, INIT);
    end

    // R10: rdata holds with no accepted read
    repeat (3) @(negedge clk);
    chk("R10 rdata held", rdata, INIT);

    // R3/R4: write-through sweep
    for (int k = 1; k <= N; k++) begin
      v = 8'(k * 37 + 11);
      wr_nv(AW'(k), v, n);
      chk($sformatf("R3 busy length word %0d", k), n, PC);
      exp_nv[k] = v; exp_sh[k] = v;
      rd(AW'(k), v); chk($sformatf("R4 stalled write ignored word %0d", k), v, exp_sh[k]);
    end

    // R9: control register layout
    wr(0, 8'hFF);
    rd(0, v); chk("R9 ctrl only bit7", v, 8'h80);

    // R5: shadow-only writes
    for (int k = 1; k <= N; k++) begin
      v = 8'(k * 53) ^ 8'h5A;
      wr(AW'(k), v);
      chk("R5 busy stays low", busy, 0);
      chk("R5 ready stays high", ready, 1);
      exp_sh[k] = v;
    end
    for (int k = 1; k <= N; k++) begin
      rd(AW'(k), v); chk($sformatf("R5 shadow word %0d", k), v, exp_sh[k]);
    end

    // R6/R7: power cycle drops shadow-only data and mode
    power_cycle(n);
    chk("R1 reload cycles again", n, N);
    rd(0, v); chk("R7 mode cleared by reset", v, 8'h00);
    for (int k = 1; k <= N; k++) begin
      rd(AW'(k), v); chk($sformatf("R6 restore word %0d", k), v, exp_nv[k]);
      exp_sh[k] = exp_nv[k];
    end

    // R8: reset in the middle of programming
    wr(3, 8'h3C);
    repeat (2) @(negedge clk);
    chk("R8 busy mid-program", busy, 1);
    rst_n = 1'b0;
    #1;
    chk("R8 busy drops on reset", busy, 0);
    power_cycle(n);
    for (int k = 1; k <= N; k++) begin
      rd(AW'(k), v); chk($sformatf("R8 word %0d after abort", k), v, exp_nv[k]);
    end

    // R4: write attempted during reload is ignored
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = 1'b1; we = 1'b1; addr = 2; wdata = 8'h00;
    repeat (2) @(negedge clk);
    req = 1'b0; we = 1'b0;
    wait_ready();
    rd(2, v); chk("R4 write during reload ignored", v, exp_nv[2]);

    // R3 again after mode toggles back
    wr(0, 8'h80);
    wr(0, 8'h00);
    wr_nv(5, 8'hC3, n);
    chk("R3 busy length after toggle", n, PC);
    exp_nv[5] = 8'hC3;
    power_cycle(n);
    rd(5, v); chk("R6 new value persists", v, 8'hC3);

    summary();
  end
endmodule